// File: doc/BRIEF.md
# Delay Tap Window Trainer

This block tunes two programmable delay settings, one after the other. The first is a command-path delay and the second a feedback-clock delay. For each setting it steps through every tap value of the delay field. At each tap it applies the value, asks an external test engine for a verdict over a start/done/pass handshake, and records where the passing region begins and ends.

When the last tap has been tried, the block picks a tap centred in the first passing region and drives it onto that channel's delay output. It also raises a success flag if any tap passed. When nothing passes, it drives a fixed mid-scale fallback tap with success low. The feedback channel starts in the same clock edge that applies the command channel's result.

A single request pulse trains both channels. A busy flag covers the whole run. Requests that arrive while busy is high are dropped.

Top module: `tap_train_dual`

## Requirements
- R1: While reset is asserted and right after it, both delay outputs hold the fallback tap 16 (mid-scale for 5-bit taps), both success flags are 0, and busy and test_start are 0.
- R2: A train_req seen at a clock edge while busy is 0 sets busy and drives cmd_tap to 0 at that edge. A train_req seen while busy is 1 has no effect, including in the cycle whose edge clears busy.
- R3: Each channel applies taps 0 through 31 in ascending order and runs exactly one test per tap. The command channel runs first. test_sel is 0 while the command channel is being tested and 1 for the feedback channel.
- R4: A tap is held on its delay output for at least one full cycle before test_start is raised. test_start is a one-cycle pulse. A second test is never started before test_done answers the first, and test_done is only taken after test_start.
- R5: The window start is the lowest tap that passes. Until a tap passes, the start is held at an out-of-range sentinel value.
- R6: The window end is the first failing tap after the first passing run. Later passing runs do not move the start or the end. With a closed window the chosen tap is floor((start + end) / 2).
- R7: If the taps are still passing when tap 31 has been tested, the chosen tap is floor((start + 31) / 2).
- R8: If no tap passes, the chosen tap is 16 and that channel's success flag is 0.
- R9: A channel's success flag is 1 exactly when its window closed or was still open at tap 31.
- R10: After a channel's last test, its delay output is driven with the chosen tap and not with tap 31. The feedback result is applied at the edge that clears busy. Outputs then hold until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_req | input | 1 | Request to train both channels |
| test_start | output | 1 | One-cycle pulse starting a test at the applied tap |
| test_sel | output | 1 | Channel under test: 0 command, 1 feedback |
| test_done | input | 1 | Test engine verdict valid |
| test_pass | input | 1 | Verdict, sampled with test_done |
| cmd_tap | output | 5 | Command-path delay tap |
| cmd_ok | output | 1 | Command channel found a passing tap |
| fb_tap | output | 5 | Feedback-clock delay tap |
| fb_ok | output | 1 | Feedback channel found a passing tap |
| busy | output | 1 | Training in progress |

## Verification
Two things can happen at the same clock edge. The feedback channel can apply its final chosen tap and clear busy while a fresh train_req is presented. The bench provokes this by raising train_req during the final-result cycle, and a per-cycle reference model expects the request to be dropped and busy to stay low afterwards. The other overlap is the command channel's result landing in the same edge that starts the feedback sweep at tap 0. The model checks both delay outputs and test_sel on every cycle across that edge, using pass patterns that exercise open, closed, empty and multi-window cases with test latencies of one to three cycles.

// File: rtl/tap_train_pkg.sv
package tap_train_pkg;
   typedef enum logic [2:0] {
      CH_IDLE,
      CH_SETTLE,
      CH_PULSE,
      CH_WAIT,
      CH_FINISH
   } chan_state_e;
endpackage

// File: rtl/tap_window_rec.sv
module tap_window_rec #(
   parameter int TAP_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             smp,
   input  logic             pass,
   input  logic [TAP_W-1:0] tap,
   output logic [TAP_W-1:0] win_lo,
   output logic [TAP_W-1:0] win_hi,
   output logic             closed,
   output logic             open_now
);
   localparam int REC_W = TAP_W + 1;
   localparam logic [REC_W-1:0] SENT = {REC_W{1'b1}};

   logic [REC_W-1:0] lo_q;
   logic [TAP_W-1:0] hi_q;
   logic             closed_q;
   logic             open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q     <= SENT;
         hi_q     <= '0;
         closed_q <= 1'b0;
         open_q   <= 1'b0;
      end else if (clr) begin
         lo_q     <= SENT;
         hi_q     <= '0;
         closed_q <= 1'b0;
         open_q   <= 1'b0;
      end else if (smp) begin
         if (pass) begin
            if (lo_q == SENT) lo_q <= {1'b0, tap};
            open_q <= 1'b1;
         end else if (open_q) begin
            if (!closed_q) hi_q <= tap;
            closed_q <= 1'b1;
            open_q   <= 1'b0;
         end
      end
   end

   assign win_lo   = lo_q[TAP_W-1:0];
   assign win_hi   = hi_q;
   assign closed   = closed_q;
   assign open_now = open_q;
endmodule

// File: rtl/tap_mid_pick.sv
module tap_mid_pick #(
   parameter int TAP_W = 5
) (
   input  logic [TAP_W-1:0] win_lo,
   input  logic [TAP_W-1:0] win_hi,
   input  logic             closed,
   input  logic             open_now,
   output logic [TAP_W-1:0] pick,
   output logic             found
);
   localparam logic [TAP_W:0]   TOP_X = {1'b0, {TAP_W{1'b1}}};
   localparam logic [TAP_W-1:0] FALL  = {1'b1, {(TAP_W-1){1'b0}}};

   logic [TAP_W:0] sum;

   always_comb begin
      if (closed) sum = {1'b0, win_lo} + {1'b0, win_hi};
      else        sum = {1'b0, win_lo} + TOP_X;
      found = closed | open_now;
      pick  = found ? sum[TAP_W:1] : FALL;
   end
endmodule

// File: rtl/tap_sweep_chan.sv
module tap_sweep_chan #(
   parameter int TAP_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             t_done,
   input  logic             t_pass,
   output logic [TAP_W-1:0] tap_o,
   output logic             ok_o,
   output logic             start_o,
   output logic             fin_o
);
   import tap_train_pkg::*;

   localparam logic [TAP_W-1:0] LAST = {TAP_W{1'b1}};
   localparam logic [TAP_W-1:0] FALL = {1'b1, {(TAP_W-1){1'b0}}};

   chan_state_e      st_q;
   logic [TAP_W-1:0] cnt_q;
   logic [TAP_W-1:0] dly_q;
   logic             ok_q;
   logic             smp;
   logic             clr;
   logic [TAP_W-1:0] lo_w;
   logic [TAP_W-1:0] hi_w;
   logic             closed_w;
   logic             open_w;
   logic [TAP_W-1:0] pick_w;
   logic             found_w;

   assign clr = (st_q == CH_IDLE) & go;
   assign smp = (st_q == CH_WAIT) & t_done;

   tap_window_rec #(.TAP_W(TAP_W)) u_rec (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .smp      (smp),
      .pass     (t_pass),
      .tap      (cnt_q),
      .win_lo   (lo_w),
      .win_hi   (hi_w),
      .closed   (closed_w),
      .open_now (open_w)
   );

   tap_mid_pick #(.TAP_W(TAP_W)) u_pick (
      .win_lo   (lo_w),
      .win_hi   (hi_w),
      .closed   (closed_w),
      .open_now (open_w),
      .pick     (pick_w),
      .found    (found_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= CH_IDLE;
         cnt_q <= '0;
         dly_q <= FALL;
         ok_q  <= 1'b0;
      end else begin
         case (st_q)
            CH_IDLE: begin
               if (go) begin
                  cnt_q <= '0;
                  dly_q <= '0;
                  st_q  <= CH_SETTLE;
               end
            end
            CH_SETTLE: st_q <= CH_PULSE;
            CH_PULSE:  st_q <= CH_WAIT;
            CH_WAIT: begin
               if (t_done) begin
                  if (cnt_q == LAST) begin
                     st_q <= CH_FINISH;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                     dly_q <= cnt_q + 1'b1;
                     st_q  <= CH_SETTLE;
                  end
               end
            end
            CH_FINISH: begin
               dly_q <= pick_w;
               ok_q  <= found_w;
               st_q  <= CH_IDLE;
            end
            default: st_q <= CH_IDLE;
         endcase
      end
   end

   assign tap_o   = dly_q;
   assign ok_o    = ok_q;
   assign start_o = (st_q == CH_PULSE);
   assign fin_o   = (st_q == CH_FINISH);
endmodule

// File: rtl/tap_train_dual.sv
module tap_train_dual #(
   parameter int TAP_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             train_req,
   output logic             test_start,
   output logic             test_sel,
   input  logic             test_done,
   input  logic             test_pass,
   output logic [TAP_W-1:0] cmd_tap,
   output logic             cmd_ok,
   output logic [TAP_W-1:0] fb_tap,
   output logic             fb_ok,
   output logic             busy
);
   localparam int NCH = 2;

   if (TAP_W < 2 || TAP_W > 8) begin : g_bad_width
      $error("tap_train_dual: TAP_W must be between 2 and 8");
   end

   logic [NCH-1:0]   go_w;
   logic [NCH-1:0]   start_w;
   logic [NCH-1:0]   fin_w;
   logic [NCH-1:0]   ok_w;
   logic [TAP_W-1:0] tap_w [NCH];
   logic             busy_q;
   logic             sel_q;
   logic             accept;

   assign accept = train_req & ~busy_q;

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      if (g == 0) begin : g_head
         assign go_w[g] = accept;
      end else begin : g_chain
         assign go_w[g] = fin_w[g-1];
      end
      tap_sweep_chan #(.TAP_W(TAP_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .go      (go_w[g]),
         .t_done  (test_done),
         .t_pass  (test_pass),
         .tap_o   (tap_w[g]),
         .ok_o    (ok_w[g]),
         .start_o (start_w[g]),
         .fin_o   (fin_w[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sel_q  <= 1'b0;
      end else begin
         if (accept)              busy_q <= 1'b1;
         else if (fin_w[NCH-1])   busy_q <= 1'b0;
         if (accept)              sel_q  <= 1'b0;
         else if (fin_w[0])       sel_q  <= 1'b1;
      end
   end

   assign test_start = |start_w;
   assign test_sel   = sel_q;
   assign cmd_tap    = tap_w[0];
   assign cmd_ok     = ok_w[0];
   assign fb_tap     = tap_w[1];
   assign fb_ok      = ok_w[1];
   assign busy       = busy_q;
endmodule

// File: rtl/tap_train_chk.sv
module tap_train_chk #(
   parameter int TAP_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             train_req,
   input logic             test_start,
   input logic             test_done,
   input logic [TAP_W-1:0] cmd_tap,
   input logic             cmd_ok,
   input logic [TAP_W-1:0] fb_tap,
   input logic             fb_ok,
   input logic             busy
);
   localparam logic [TAP_W-1:0] FALL = {1'b1, {(TAP_W-1){1'b0}}};

   logic inflight;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          inflight <= 1'b0;
      else if (test_start) inflight <= 1'b1;
      else if (test_done)  inflight <= 1'b0;
   end

   AST_TAP_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
      test_start |-> ($stable(cmd_tap) && $stable(fb_tap))); // R4
   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      test_start |=> !test_start); // R4
   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      test_start |-> !inflight); // R4
   AST_START_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      test_start |-> busy); // R2
   AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && train_req) |=> (busy && cmd_tap == '0)); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !train_req) |=> ($stable(cmd_tap) && $stable(fb_tap) &&
                                 $stable(cmd_ok) && $stable(fb_ok))); // R10
   AST_FALLBACK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ((cmd_ok || cmd_tap == FALL) && (fb_ok || fb_tap == FALL))); // R8
endmodule

bind tap_train_dual tap_train_chk #(.TAP_W(TAP_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .train_req  (train_req),
   .test_start (test_start),
   .test_done  (test_done),
   .cmd_tap    (cmd_tap),
   .cmd_ok     (cmd_ok),
   .fb_tap     (fb_tap),
   .fb_ok      (fb_ok),
   .busy       (busy)
);

// File: tb/tb_tap_train_dual.sv
module tb_tap_train_dual;
   localparam int TW   = 5;
   localparam int MAXT = 31;
   localparam int FALL = 16;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          train_req = 1'b0;
   logic          test_done = 1'b0;
   logic          test_pass = 1'b0;
   logic          test_start, test_sel, cmd_ok, fb_ok, busy;
   logic [TW-1:0] cmd_tap, fb_tap;

   tap_train_dual #(.TAP_W(TW)) dut (
      .clk(clk), .rst_n(rst_n), .train_req(train_req),
      .test_start(test_start), .test_sel(test_sel),
      .test_done(test_done), .test_pass(test_pass),
      .cmd_tap(cmd_tap), .cmd_ok(cmd_ok),
      .fb_tap(fb_tap), .fb_ok(fb_ok), .busy(busy));

   int total = 0;
   int bad   = 0;
   int pat   = 0;
   int lat   = 1;

   // reference model state
   bit m_run = 0;
   int m_ch = 0, m_tap = 0, m_step = 0, m_sel = 0;
   int m_tap_o[2] = '{FALL, FALL};
   bit m_ok[2] = '{0, 0};
   bit res[2][32];

   task automatic chk(input bit cond, input string req, input int act, input int exp);
      total++;
      if (!cond) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit pass_fn(int p, int ch, int t);
      case (p)
         0: return (ch == 0) ? (t >= 5 && t <= 20) : (t >= 10);
         1: return (ch == 0) ? 1'b0 : 1'b1;
         2: return (ch == 0) ? ((t >= 2 && t <= 4) || t >= 10) : (t == 31);
         default: return (ch == 0) ? (t == 0) : (t <= 30);
      endcase
   endfunction

   function automatic int pick_tap(int ch, output bit ok);
      int s = -1;
      for (int i = 0; i <= MAXT; i++) if (s < 0 && res[ch][i]) s = i;
      if (s < 0) begin ok = 0; return FALL; end
      ok = 1;
      for (int i = s; i <= MAXT; i++) if (!res[ch][i]) return (s + i) / 2;
      return (s + MAXT) / 2;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_sel = 0; m_tap_o = '{FALL, FALL}; m_ok = '{0, 0};
      end else if (!m_run) begin
         if (train_req) begin
            m_run = 1; m_ch = 0; m_tap = 0; m_step = 0; m_sel = 0; m_tap_o[0] = 0;
         end
      end else begin
         case (m_step)
            0: m_step = 1;
            1: m_step = 2;
            2: if (test_done) begin
                  res[m_ch][m_tap] = test_pass;
                  if (m_tap == MAXT) m_step = 3;
                  else begin m_tap++; m_tap_o[m_ch] = m_tap; m_step = 0; end
               end
            default: begin
               bit okv;
               m_tap_o[m_ch] = pick_tap(m_ch, okv);
               m_ok[m_ch] = okv;
               if (m_ch == 0) begin
                  m_ch = 1; m_sel = 1; m_tap = 0; m_step = 0; m_tap_o[1] = 0;
               end else m_run = 0;
            end
         endcase
      end
   end

   // per-cycle compare and test responder
   bit pend = 0;
   int rcnt = 0, cap_tap = 0, cap_sel = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy == m_run, "R2 busy", busy, m_run);
         chk(test_start == (m_run && m_step == 1), "R4 test_start", test_start, (m_run && m_step == 1));
         chk(int'(test_sel) == m_sel, "R3 test_sel", test_sel, m_sel);
         chk(int'(cmd_tap) == m_tap_o[0], "R3 cmd_tap", cmd_tap, m_tap_o[0]);
         chk(int'(fb_tap) == m_tap_o[1], "R10 fb_tap", fb_tap, m_tap_o[1]);
         chk(cmd_ok == m_ok[0] && fb_ok == m_ok[1], "R9 ok flags", {cmd_ok, fb_ok}, {m_ok[0], m_ok[1]});
      end
      test_done = 1'b0;
      test_pass = 1'b0;
      if (pend) begin
         if (rcnt == 0) begin
            test_done = 1'b1;
            test_pass = pass_fn(pat, cap_sel, cap_tap);
            pend = 0;
         end else rcnt--;
      end
      if (test_start) begin
         pend = 1; rcnt = lat - 1; cap_sel = test_sel;
         cap_tap = test_sel ? int'(fb_tap) : int'(cmd_tap);
      end
   end

   task automatic run_pattern(input int p, input int l, input int e_cmd, input bit e_cok,
                              input int e_fb, input bit e_fok, input string rc, input string rf);
      int n = 0;
      int hold_c, hold_f;
      pat = p; lat = l;
      @(negedge clk); train_req = 1'b1;
      @(negedge clk); train_req = 1'b0;
      chk(busy == 1'b1 && cmd_tap == '0, "R2 accept", {busy, cmd_tap}, {1'b1, 5'd0});
      while (busy) begin
         @(negedge clk);
         n++;
         train_req = (p == 1 && n == 40) || (p == 2 && m_run && m_ch == 1 && m_step == 3);
      end
      train_req = 1'b0;
      @(negedge clk);
      chk(busy == 1'b0, "R2 request ignored at finish", busy, 0);
      chk(int'(cmd_tap) == e_cmd, {rc, " cmd_tap"}, cmd_tap, e_cmd);
      chk(cmd_ok == e_cok, "R9 cmd_ok", cmd_ok, e_cok);
      chk(int'(fb_tap) == e_fb, {rf, " fb_tap"}, fb_tap, e_fb);
      chk(fb_ok == e_fok, "R9 fb_ok", fb_ok, e_fok);
      hold_c = cmd_tap; hold_f = fb_tap;
      repeat (3) @(negedge clk);
      chk(int'(cmd_tap) == hold_c && int'(fb_tap) == hold_f, "R10 hold while idle",
          {cmd_tap, fb_tap}, {hold_c[4:0], hold_f[4:0]});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(cmd_tap == 5'd16 && fb_tap == 5'd16, "R1 reset taps", {cmd_tap, fb_tap}, {5'd16, 5'd16});
      chk(!cmd_ok && !fb_ok && !busy && !test_start, "R1 reset flags",
          {cmd_ok, fb_ok, busy, test_start}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_tap == 5'd16 && !busy, "R1 after reset", {busy, cmd_tap}, 16);
      run_pattern(0, 1, 13, 1, 20, 1, "R6", "R7");
      run_pattern(1, 2, 16, 0, 15, 1, "R8", "R7");
      run_pattern(2, 3, 3, 1, 31, 1, "R6", "R5");
      run_pattern(3, 1, 0, 1, 15, 1, "R5", "R6");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule